// File: doc/BRIEF.md
# Linked-List Source Tile Fetch Handler

This block is a command handler that sits in front of a gridding accelerator. The accelerator's irregularly placed source samples are grouped by spatial tile. Each tile is kept in memory as a chain of nodes. The nodes may be scattered anywhere in the address space, and each node carries a block of several samples that all belong to the same tile. When the handler receives a load-source command carrying a head pointer, it walks the chain. For each node it reads a two-word header, hands the node's sample block to a DMA engine as a single burst, and then moves on to the next node until it reaches the end marker.

The same handler also decodes two other commands. A tile-initialisation command writes one accelerator configuration register. A limit command sets the largest number of nodes that one walk may visit. If a walk would go beyond that number, it stops and raises an error flag, so a corrupted, cyclic chain cannot hang the accelerator. The handler takes one command at a time and reports the end of every walk with a one-cycle done pulse.

Top module: `srclist_fetch`

## Requirements
- R1: After reset, cmd_ready is 1, walk_err is 0, and mem_rd_req, dma_req, cfg_we and done are all 0.
- R2: The command opcode is cmd_word[31:30], encoded as 00 no-op, 01 load-source, 10 tile-init and 11 set-limit. A command is taken only in a cycle where cmd_valid and cmd_ready are both 1, and cmd_ready is 0 for the whole of a walk. A no-op changes nothing that can be seen at the ports: it starts no reads, writes no configuration and leaves the node limit unchanged.
- R3: A tile-init command gives a configuration index in cmd_word[27:24] and a value in cmd_word[15:0]. One cycle after the command is taken, cfg_we is high for exactly one cycle, with cfg_idx and cfg_data carrying those fields.
- R4: For each node at address P, the handler reads the next pointer at P and then the sample count at P+1. Only one read is outstanding at a time. Each read is a one-cycle mem_rd_req, and the handler waits for mem_rd_valid before it moves on.
- R5: For a node whose count (the low LEN_W bits of the count word) is not zero, dma_req is raised with dma_addr = P+2 and dma_len = that count. The request and its fields are held until dma_ack. The handler then waits for dma_done before it reads the next header.
- R6: A node whose count is zero issues no DMA request. Its next pointer is still followed.
- R7: A next pointer of all ones (16'hFFFF at the default width) ends the walk. A load-source command whose head pointer is all ones makes no reads and ends with done and no error.
- R8: done is high for exactly one cycle after the last step of a walk, and cmd_ready returns to 1 in the following cycle. A walk that ends at the end marker shows walk_err = 0 together with done.
- R9: The node limit is set from cmd_word[NODE_W-1:0] by a set-limit command, and its reset value is LIMIT_RST (16). If a node has been processed, its next pointer is not the end marker, and the number of nodes visited has already reached the limit, the walk makes no further reads and ends with done and walk_err = 1. With a limit of 0, a head pointer that is not the end marker gives done and walk_err = 1 with no reads at all.
- R10: walk_err keeps its value after done and is cleared only when the next load-source command is taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command word offered |
| cmd_word | input | 32 | Command: opcode in [31:30], with fields depending on the opcode |
| cmd_ready | output | 1 | Handler is idle and will take a command |
| mem_rd_req | output | 1 | One-cycle header read request |
| mem_rd_addr | output | AW | Header word address |
| mem_rd_valid | input | 1 | Read data returned |
| mem_rd_data | input | DW | Returned header word |
| dma_req | output | 1 | Burst request for a node's sample block |
| dma_addr | output | AW | First sample address (node address + 2) |
| dma_len | output | LEN_W | Number of samples in the burst |
| dma_ack | input | 1 | DMA engine has accepted the request |
| dma_done | input | 1 | DMA burst complete |
| cfg_we | output | 1 | Configuration register write strobe |
| cfg_idx | output | 4 | Configuration register index |
| cfg_data | output | 16 | Configuration register value |
| done | output | 1 | One-cycle end-of-walk pulse |
| walk_err | output | 1 | Last walk was stopped by the node limit |

## Verification
The hardest case to reach from the ports is the stop at the node limit. The limit must be reached on exactly the right node, while the end-marker check still takes priority on the last node. The bench writes node chains into its memory model so that these cases come up on purpose. It builds a true cycle in which two nodes point at each other, and a three-node chain that it walks with a limit of three and then of two. It also walks that chain with a limit of zero and an all-ones head. The chains include a zero-count node between two populated ones, and a count word whose upper bits are set. Before each walk, the scoreboard is given the exact order of header reads, bursts and the final done flag, and every event the handler produces is matched against that order.

// File: rtl/llf_pkg.sv
package llf_pkg;

  typedef enum logic [1:0] {
    OP_NOP   = 2'b00,
    OP_LOAD  = 2'b01,
    OP_INIT  = 2'b10,
    OP_LIMIT = 2'b11
  } llf_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ_HDR,
    ST_ISSUE_DMA,
    ST_WAIT_DMA,
    ST_DONE
  } llf_walk_e;

  typedef enum logic [2:0] {
    HP_IDLE,
    HP_ASK_NEXT,
    HP_WAIT_NEXT,
    HP_ASK_COUNT,
    HP_WAIT_COUNT
  } llf_hdr_e;

  localparam int CMD_W       = 32;
  localparam int OP_LSB      = 30;
  localparam int CFG_IDX_LSB = 24;
  localparam int CFG_IDX_W   = 4;
  localparam int CFG_VAL_W   = 16;

endpackage

// File: rtl/llf_cmd_decode.sv
module llf_cmd_decode
  import llf_pkg::*;
#(
  parameter int AW        = 16,
  parameter int NODE_W    = 8,
  parameter int LIMIT_RST = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [CMD_W-1:0]     cmd_word,
  input  logic                 cmd_fire,
  output logic                 load_fire,
  output logic [AW-1:0]        head_ptr,
  output logic [NODE_W-1:0]    limit,
  output logic                 cfg_we,
  output logic [CFG_IDX_W-1:0] cfg_idx,
  output logic [CFG_VAL_W-1:0] cfg_data
);

  llf_op_e               op;
  logic                  limit_en;
  logic                  cfg_en;
  logic [NODE_W-1:0]     limit_q;
  logic                  we_q;
  logic [CFG_IDX_W-1:0]  idx_q;
  logic [CFG_VAL_W-1:0]  val_q;
  logic                  unused_cmd_bits;

  always_comb begin
    op        = llf_op_e'(cmd_word[OP_LSB +: 2]);
    load_fire = cmd_fire && (op == OP_LOAD);
    limit_en  = cmd_fire && (op == OP_LIMIT);
    cfg_en    = cmd_fire && (op == OP_INIT);
    head_ptr  = cmd_word[AW-1:0];
  end

  assign unused_cmd_bits = ^cmd_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      limit_q <= NODE_W'(LIMIT_RST);
    end else if (limit_en) begin
      limit_q <= cmd_word[NODE_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q <= 1'b0;
    end else begin
      we_q <= cfg_en;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      val_q <= '0;
    end else if (cfg_en) begin
      idx_q <= cmd_word[CFG_IDX_LSB +: CFG_IDX_W];
      val_q <= cmd_word[CFG_VAL_W-1:0];
    end
  end

  assign limit    = limit_q;
  assign cfg_we   = we_q;
  assign cfg_idx  = idx_q;
  assign cfg_data = val_q;

endmodule

// File: rtl/llf_hdr_reader.sv
module llf_hdr_reader
  import llf_pkg::*;
#(
  parameter int AW    = 16,
  parameter int DW    = 16,
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             kick,
  input  logic [AW-1:0]    base,
  output logic             rd_req,
  output logic [AW-1:0]    rd_addr,
  input  logic             rd_valid,
  input  logic [DW-1:0]    rd_data,
  output logic             hdr_done,
  output logic [AW-1:0]    hdr_next,
  output logic [LEN_W-1:0] hdr_count
);

  llf_hdr_e        phase_q, phase_d;
  logic [AW-1:0]   base_q;
  logic [AW-1:0]   next_q;
  logic            base_en;
  logic            next_en;
  logic            unused_rd_bits;

  always_comb begin
    phase_d = phase_q;
    case (phase_q)
      HP_IDLE:       if (kick) phase_d = HP_ASK_NEXT;
      HP_ASK_NEXT:   phase_d = HP_WAIT_NEXT;
      HP_WAIT_NEXT:  if (rd_valid) phase_d = HP_ASK_COUNT;
      HP_ASK_COUNT:  phase_d = HP_WAIT_COUNT;
      HP_WAIT_COUNT: if (rd_valid) phase_d = HP_IDLE;
      default:       phase_d = HP_IDLE;
    endcase
  end

  always_comb begin
    base_en = (phase_q == HP_IDLE) && kick;
    next_en = (phase_q == HP_WAIT_NEXT) && rd_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= HP_IDLE;
    end else begin
      phase_q <= phase_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
    end else if (base_en) begin
      base_q <= base;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      next_q <= '0;
    end else if (next_en) begin
      next_q <= rd_data[AW-1:0];
    end
  end

  assign unused_rd_bits = ^rd_data;

  always_comb begin
    rd_req    = (phase_q == HP_ASK_NEXT) || (phase_q == HP_ASK_COUNT);
    rd_addr   = (phase_q == HP_ASK_COUNT) ? base_q + AW'(1) : base_q;
    hdr_done  = (phase_q == HP_WAIT_COUNT) && rd_valid;
    hdr_next  = next_q;
    hdr_count = rd_data[LEN_W-1:0];
  end

endmodule

// File: rtl/llf_walk_fsm.sv
module llf_walk_fsm
  import llf_pkg::*;
#(
  parameter int AW     = 16,
  parameter int LEN_W  = 8,
  parameter int NODE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_fire,
  input  logic [AW-1:0]     head_ptr,
  input  logic [NODE_W-1:0] limit,
  input  logic              hdr_done,
  input  logic [AW-1:0]     hdr_next,
  input  logic [LEN_W-1:0]  hdr_count,
  input  logic              dma_ack,
  input  logic              dma_done,
  output logic              cmd_ready,
  output logic              hdr_kick,
  output logic [AW-1:0]     node_ptr,
  output logic              dma_req,
  output logic [AW-1:0]     dma_addr,
  output logic [LEN_W-1:0]  dma_len,
  output logic              done,
  output logic              walk_err
);

  localparam logic [AW-1:0] END_PTR = '1;

  llf_walk_e          state_q, state_d;
  logic [AW-1:0]      ptr_q, ptr_d;
  logic [LEN_W-1:0]   cnt_q, cnt_d;
  logic [NODE_W-1:0]  nodes_q, nodes_d;
  logic               err_q, err_d;
  logic               kick_q, kick_d;
  logic [NODE_W:0]    visited;
  logic               step;

  always_comb begin
    visited = (state_q == ST_READ_HDR) ? ({1'b0, nodes_q} + (NODE_W+1)'(1))
                                       : {1'b0, nodes_q};
  end

  always_comb begin
    state_d = state_q;
    ptr_d   = ptr_q;
    cnt_d   = cnt_q;
    nodes_d = nodes_q;
    err_d   = err_q;
    kick_d  = 1'b0;
    step    = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (load_fire) begin
          nodes_d = '0;
          err_d   = 1'b0;
          ptr_d   = head_ptr;
          if (head_ptr == END_PTR) begin
            state_d = ST_DONE;
          end else if (limit == '0) begin
            state_d = ST_DONE;
            err_d   = 1'b1;
          end else begin
            state_d = ST_READ_HDR;
            kick_d  = 1'b1;
          end
        end
      end
      ST_READ_HDR: begin
        if (hdr_done) begin
          nodes_d = visited[NODE_W-1:0];
          cnt_d   = hdr_count;
          if (hdr_count != '0) state_d = ST_ISSUE_DMA;
          else                 step    = 1'b1;
        end
      end
      ST_ISSUE_DMA: if (dma_ack)  state_d = ST_WAIT_DMA;
      ST_WAIT_DMA:  if (dma_done) step    = 1'b1;
      ST_DONE:      state_d = ST_IDLE;
      default:      state_d = ST_IDLE;
    endcase
    if (step) begin
      if (hdr_next == END_PTR) begin
        state_d = ST_DONE;
      end else if (visited >= {1'b0, limit}) begin
        state_d = ST_DONE;
        err_d   = 1'b1;
      end else begin
        ptr_d   = hdr_next;
        state_d = ST_READ_HDR;
        kick_d  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      kick_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      kick_q  <= kick_d;
      err_q   <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q   <= '0;
      cnt_q   <= '0;
      nodes_q <= '0;
    end else begin
      ptr_q   <= ptr_d;
      cnt_q   <= cnt_d;
      nodes_q <= nodes_d;
    end
  end

  always_comb begin
    cmd_ready = (state_q == ST_IDLE);
    hdr_kick  = kick_q;
    node_ptr  = ptr_q;
    dma_req   = (state_q == ST_ISSUE_DMA);
    dma_addr  = ptr_q + AW'(2);
    dma_len   = cnt_q;
    done      = (state_q == ST_DONE);
    walk_err  = err_q;
  end

endmodule

// File: rtl/srclist_fetch.sv
module srclist_fetch
  import llf_pkg::*;
#(
  parameter int AW        = 16,
  parameter int DW        = 16,
  parameter int LEN_W     = 8,
  parameter int NODE_W    = 8,
  parameter int LIMIT_RST = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_valid,
  input  logic [CMD_W-1:0]     cmd_word,
  output logic                 cmd_ready,
  output logic                 mem_rd_req,
  output logic [AW-1:0]        mem_rd_addr,
  input  logic                 mem_rd_valid,
  input  logic [DW-1:0]        mem_rd_data,
  output logic                 dma_req,
  output logic [AW-1:0]        dma_addr,
  output logic [LEN_W-1:0]     dma_len,
  input  logic                 dma_ack,
  input  logic                 dma_done,
  output logic                 cfg_we,
  output logic [CFG_IDX_W-1:0] cfg_idx,
  output logic [CFG_VAL_W-1:0] cfg_data,
  output logic                 done,
  output logic                 walk_err
);

  logic              cmd_fire;
  logic              load_fire;
  logic [AW-1:0]     head_ptr;
  logic [NODE_W-1:0] limit;
  logic              hdr_kick;
  logic [AW-1:0]     node_ptr;
  logic              hdr_done;
  logic [AW-1:0]     hdr_next;
  logic [LEN_W-1:0]  hdr_count;

  assign cmd_fire = cmd_valid && cmd_ready;

  llf_cmd_decode #(
    .AW(AW), .NODE_W(NODE_W), .LIMIT_RST(LIMIT_RST)
  ) u_decode (
    .clk(clk), .rst_n(rst_n),
    .cmd_word(cmd_word), .cmd_fire(cmd_fire),
    .load_fire(load_fire), .head_ptr(head_ptr), .limit(limit),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_data(cfg_data)
  );

  llf_hdr_reader #(
    .AW(AW), .DW(DW), .LEN_W(LEN_W)
  ) u_hdr (
    .clk(clk), .rst_n(rst_n),
    .kick(hdr_kick), .base(node_ptr),
    .rd_req(mem_rd_req), .rd_addr(mem_rd_addr),
    .rd_valid(mem_rd_valid), .rd_data(mem_rd_data),
    .hdr_done(hdr_done), .hdr_next(hdr_next), .hdr_count(hdr_count)
  );

  llf_walk_fsm #(
    .AW(AW), .LEN_W(LEN_W), .NODE_W(NODE_W)
  ) u_walk (
    .clk(clk), .rst_n(rst_n),
    .load_fire(load_fire), .head_ptr(head_ptr), .limit(limit),
    .hdr_done(hdr_done), .hdr_next(hdr_next), .hdr_count(hdr_count),
    .dma_ack(dma_ack), .dma_done(dma_done),
    .cmd_ready(cmd_ready), .hdr_kick(hdr_kick), .node_ptr(node_ptr),
    .dma_req(dma_req), .dma_addr(dma_addr), .dma_len(dma_len),
    .done(done), .walk_err(walk_err)
  );

endmodule

// File: rtl/llf_walk_checker.sv
module llf_walk_checker
  import llf_pkg::*;
#(
  parameter int AW    = 16,
  parameter int LEN_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic [CMD_W-1:0] cmd_word,
  input logic             cmd_ready,
  input logic             mem_rd_req,
  input logic             mem_rd_valid,
  input logic             dma_req,
  input logic [AW-1:0]    dma_addr,
  input logic [LEN_W-1:0] dma_len,
  input logic             dma_ack,
  input logic             cfg_we,
  input logic             done,
  input logic             walk_err
);

  logic [1:0] outstanding_q;
  logic       init_take;
  logic       load_take;

  assign init_take = cmd_valid && cmd_ready && (cmd_word[OP_LSB +: 2] == 2'b10);
  assign load_take = cmd_valid && cmd_ready && (cmd_word[OP_LSB +: 2] == 2'b01);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outstanding_q <= '0;
    end else begin
      case ({mem_rd_req, mem_rd_valid})
        2'b10:   outstanding_q <= outstanding_q + 2'd1;
        2'b01:   outstanding_q <= outstanding_q - 2'd1;
        default: outstanding_q <= outstanding_q;
      endcase
    end
  end

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> (!dma_req && !mem_rd_req));

  assert_cfg_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    init_take |=> cfg_we);

  assert_one_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req |-> (outstanding_q == 2'd0));

  assert_dma_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_req && !dma_ack) |=> (dma_req && $stable(dma_addr) && $stable(dma_len)));

  assert_no_empty_burst_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> (dma_len != '0));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && cmd_ready));

  assert_err_with_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(walk_err) |-> done);

  assert_err_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_err && !load_take) |=> walk_err);

endmodule

bind srclist_fetch llf_walk_checker #(.AW(AW), .LEN_W(LEN_W)) u_walk_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
  .cmd_ready(cmd_ready), .mem_rd_req(mem_rd_req), .mem_rd_valid(mem_rd_valid),
  .dma_req(dma_req), .dma_addr(dma_addr), .dma_len(dma_len), .dma_ack(dma_ack),
  .cfg_we(cfg_we), .done(done), .walk_err(walk_err)
);

// File: tb/srclist_fetch_bench.sv
module srclist_fetch_bench;

  localparam int AW = 16, DW = 16, LEN_W = 8, NODE_W = 8;

  logic              clk, rst_n;
  logic              cmd_valid;
  logic [31:0]       cmd_word;
  logic              cmd_ready;
  logic              mem_rd_req;
  logic [AW-1:0]     mem_rd_addr;
  logic              mem_rd_valid;
  logic [DW-1:0]     mem_rd_data;
  logic              dma_req;
  logic [AW-1:0]     dma_addr;
  logic [LEN_W-1:0]  dma_len;
  logic              dma_ack, dma_done;
  logic              cfg_we;
  logic [3:0]        cfg_idx;
  logic [15:0]       cfg_data;
  logic              done, walk_err;

  srclist_fetch #(.AW(AW), .DW(DW), .LEN_W(LEN_W), .NODE_W(NODE_W)) u_srclist_fetch (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
    .cmd_ready(cmd_ready), .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
    .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data), .dma_req(dma_req),
    .dma_addr(dma_addr), .dma_len(dma_len), .dma_ack(dma_ack), .dma_done(dma_done),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_data(cfg_data), .done(done),
    .walk_err(walk_err)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int          checks = 0;
  int          fails = 0;
  int          done_seen = 0;
  logic [33:0] exp_q[$];
  string       tag_q[$];
  logic [15:0] mem [0:255];

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  task automatic check(bit ok, string tag, logic [33:0] act, logic [33:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // memory model: two-cycle read latency
  logic       p1v;
  logic [7:0] p1a;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p1v <= 1'b0; p1a <= '0; mem_rd_valid <= 1'b0; mem_rd_data <= '0;
    end else begin
      p1v <= mem_rd_req;
      p1a <= mem_rd_addr[7:0];
      mem_rd_valid <= p1v;
      mem_rd_data <= mem[p1a];
    end
  end

  // DMA model: ack one cycle after request, done after len cycles
  logic       dbusy;
  logic [8:0] dleft;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dma_ack <= 1'b0; dma_done <= 1'b0; dbusy <= 1'b0; dleft <= '0;
    end else begin
      dma_done <= 1'b0;
      if (dbusy) begin
        if (dleft <= 9'd1) begin dbusy <= 1'b0; dma_done <= 1'b1; end
        else dleft <= dleft - 9'd1;
      end
      dma_ack <= dma_req && !dma_ack && !dbusy;
      if (dma_req && dma_ack) begin dbusy <= 1'b1; dleft <= {1'b0, dma_len}; end
    end
  end

  task automatic take(logic [33:0] ev);
    logic [33:0] e;
    string t;
    if (exp_q.size() == 0) begin
      check(1'b0, "R2 unexpected event", ev, '0);
    end else begin
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(ev == e, t, ev, e);
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_rd_req) take({2'd0, mem_rd_addr, 16'h0});
      if (dma_req && dma_ack) take({2'd1, dma_addr, 8'h0, dma_len});
      if (cfg_we) take({2'd2, 12'h0, cfg_idx, cfg_data});
      if (done) begin
        take({2'd3, 16'h0, 15'h0, walk_err});
        done_seen++;
      end
    end
  end

  // driver helpers
  task automatic push(logic [33:0] ev, string tag);
    exp_q.push_back(ev);
    tag_q.push_back(tag);
  endtask

  task automatic exp_node(logic [15:0] p, logic [7:0] cnt, string tag);
    push({2'd0, p, 16'h0}, {tag, " R4 next-pointer read"});
    push({2'd0, p + 16'd1, 16'h0}, {tag, " R4 count read"});
    if (cnt != 0) push({2'd1, p + 16'd2, 8'h0, cnt}, {tag, " R5 burst"});
  endtask

  task automatic exp_done(bit err, string tag);
    push({2'd3, 16'h0, 15'h0, err}, tag);
  endtask

  task automatic set_node(logic [7:0] p, logic [15:0] nxt, logic [15:0] cw);
    mem[p] = nxt;
    mem[p + 8'd1] = cw;
  endtask

  task automatic send(logic [31:0] w);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1;
    cmd_word = w;
    @(negedge clk);
    cmd_valid = 1'b0;
    cmd_word = '0;
  endtask

  task automatic run_load(logic [15:0] head);
    int s;
    int t;
    s = done_seen;
    t = 0;
    send({2'b01, 14'h0, head});
    while (done_seen == s && t < 3000) begin
      @(negedge clk);
      t++;
    end
    if (done_seen == s) check(1'b0, "R8 walk never finished", 34'h0, 34'h1);
    @(negedge clk);
  endtask

  task automatic drained(string tag);
    check(exp_q.size() == 0, tag, 34'(exp_q.size()), 34'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R8 watchdog: actual hung expected finished");
    report();
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 16'h0;
    rst_n = 1'b0;
    cmd_valid = 1'b0;
    cmd_word = '0;
    repeat (3) @(negedge clk);
    check({cmd_ready, walk_err, mem_rd_req, dma_req, cfg_we, done} == 6'b100000,
          "R1 reset outputs", 34'({cmd_ready, walk_err, mem_rd_req, dma_req, cfg_we, done}),
          34'b100000);
    rst_n = 1'b1;
    @(negedge clk);

    // R3 tile-init writes
    push({2'd2, 12'h0, 4'h5, 16'hBEEF}, "R3 cfg write idx 5");
    send({2'b10, 2'b00, 4'h5, 8'h00, 16'hBEEF});
    push({2'd2, 12'h0, 4'hF, 16'h0001}, "R3 cfg write idx F");
    send({2'b10, 2'b00, 4'hF, 8'hFF, 16'h0001});
    repeat (3) @(negedge clk);
    drained("R3 writes drained");

    // chain A: 0x40 -> 0x10 (zero count) -> 0x80 -> end
    set_node(8'h40, 16'h0010, 16'h0003);
    set_node(8'h10, 16'h0080, 16'h0000);
    set_node(8'h80, 16'hFFFF, 16'h0005);
    exp_node(16'h40, 8'd3, "A1");
    exp_node(16'h10, 8'd0, "A2 R6 zero count");
    exp_node(16'h80, 8'd5, "A3");
    exp_done(1'b0, "R8 chain A ends clean");
    run_load(16'h0040);
    drained("R6 chain A drained");
    check(cmd_ready == 1'b1, "R8 ready after walk", 34'(cmd_ready), 34'h1);

    // empty list
    exp_done(1'b0, "R7 all-ones head");
    run_load(16'hFFFF);
    drained("R7 empty head no reads");

    // limit equals chain length: clean
    send({2'b11, 22'h0, 8'd3});
    exp_node(16'h40, 8'd3, "L3a");
    exp_node(16'h10, 8'd0, "L3b");
    exp_node(16'h80, 8'd5, "L3c");
    exp_done(1'b0, "R9 limit 3 chain of 3 clean");
    run_load(16'h0040);
    drained("R9 limit 3 drained");

    // limit 2: abort after second node
    send({2'b11, 22'h0, 8'd2});
    exp_node(16'h40, 8'd3, "L2a");
    exp_node(16'h10, 8'd0, "L2b");
    exp_done(1'b1, "R9 limit 2 abort");
    run_load(16'h0040);
    drained("R9 limit 2 no further reads");
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(walk_err == 1'b1, "R10 error held", 34'(walk_err), 34'h1);
    end

    // no-op whose low bits would read as limit 1: must be ignored
    send(32'h0000_0001);
    repeat (10) @(negedge clk);
    drained("R2 no-op made no events");
    check(cmd_ready == 1'b1, "R2 ready after no-op", 34'(cmd_ready), 34'h1);
    set_node(8'h50, 16'h0060, 16'h0002);
    set_node(8'h60, 16'hFFFF, 16'h0001);
    exp_node(16'h50, 8'd2, "B1");
    exp_node(16'h60, 8'd1, "B2");
    exp_done(1'b0, "R10 error cleared, R2 limit kept at 2");
    run_load(16'h0050);
    drained("R2 chain B drained");

    // cyclic chain with limit 3
    send({2'b11, 22'h0, 8'd3});
    set_node(8'h20, 16'h0030, 16'h0001);
    set_node(8'h30, 16'h0020, 16'h0001);
    exp_node(16'h20, 8'd1, "C1");
    exp_node(16'h30, 8'd1, "C2");
    exp_node(16'h20, 8'd1, "C3");
    exp_done(1'b1, "R9 cycle aborted");
    run_load(16'h0020);
    drained("R9 cycle drained");

    // limit 0
    send({2'b11, 22'h0, 8'd0});
    exp_done(1'b1, "R9 limit 0 immediate abort");
    run_load(16'h0040);
    drained("R9 limit 0 no reads");
    exp_done(1'b0, "R7 end marker before limit");
    run_load(16'hFFFF);
    drained("R7 empty head at limit 0");

    // count word with upper bits set, full-width count
    send({2'b11, 22'h0, 8'd16});
    set_node(8'h90, 16'hFFFF, 16'h12FF);
    exp_node(16'h90, 8'hFF, "R5 wide count");
    exp_done(1'b0, "R8 wide count clean");
    run_load(16'h0090);
    drained("R5 wide count drained");

    report();
    $finish;
  end

endmodule